// File: doc/BRIEF.md
# Cartridge Ethernet Glue Logic

This block connects an 8-bit home computer expansion port to an Ethernet controller that runs in 8-bit mode, and to an optional banked EPROM on the same cartridge. On the network side it watches one of the host's two 256-byte I/O pages, chosen by a strap input. It recognises the 16-byte register window at a fixed 16-byte slot in that page and produces the controller chip select, a 4-bit register address and active-low ISA read and write strobes. Each 16-bit controller register appears as two consecutive bytes, with the low byte at the even offset.

A mapping strap can exchange the lower and upper 8-byte halves of the window. In that exchanged layout the pair at window offsets 0 and 1 belongs to other cartridge logic, so the controller is not selected there. On the ROM side, an enable strap gates every EPROM select. A 64/128 strap picks which host ROM strobes open the EPROM and how address bit 13 is formed. A 4-bit bank input supplies the EPROM address bits above bit 13. The controller interrupt is never passed to the host.

Every output is registered once on `clk`. The outputs seen after a rising edge reflect the port inputs sampled at that edge. Read data is muxed combinationally from the data input of whichever device the registered cycle selected.

Top module: `cnic_glue`

## Requirements
- R1: The controller is selected (`nic_cs_n` low one clock later) only when `phi2` is 1, the I/O strobe picked by `page_sel` is low, and `host_addr[7:4]` equals `BASE_SLOT` (default 0). `page_sel`=0 uses `io1_n` and `page_sel`=1 uses `io2_n`. The other strobe is ignored.
- R2: With `map_swap`=0, `nic_addr` equals `host_addr[3:0]`, so the low byte of each 16-bit register sits at the even offset.
- R3: With `map_swap`=1, `nic_addr` equals `host_addr[3:0]` with bit 3 inverted. Window offsets 0 and 1 then neither select the controller nor enable the host data bus.
- R4: On a selected cycle, `rw`=1 drives `isa_ior_n` low and `rw`=0 drives `isa_iow_n` low, one clock later. Both strobes are high on every cycle that does not select the controller.
- R5: `nic_wdata` captures `host_wdata` on the first clock of a write strobe. It holds that value unchanged for as long as `isa_iow_n` stays low, even if `host_wdata` changes.
- R6: `host_oe` is 1 only after a decoded controller read or EPROM read. In that case `host_rdata` equals `nic_rdata` or `rom_rdata` respectively. Otherwise `host_oe` is 0 and `host_rdata` is 0.
- R7: `host_irq_n` is always 1.
- R8: With `rom_en`=0, `rom_ce_n`, `exrom_n` and `game_n` stay 1 and no ROM read enables `host_oe`.
- R9: `rom_addr_hi` is `{bank_sel, a13}`: `bank_sel` forms EPROM address bits 17..14 and `a13` is EPROM bit 13.
- R10: In 64 mode (`mode128`=0, `rom_en`=1), `exrom_n` and `game_n` are 0. A read with `phi2`=1 and either `roml_n` or `romh_n` low selects the EPROM, with `a13`=0 for `roml_n` and `a13`=1 for `romh_n`.
- R11: In 128 mode (`mode128`=1, `rom_en`=1), `exrom_n` and `game_n` stay 1. Only `roml_n` selects the EPROM, with `a13` = `host_addr[13]`. `romh_n` alone is ignored.
- R12: While `rst` is 1 and on the first clock after it, all strobes and selects are inactive (high), `host_oe`=0, and `nic_addr`, `nic_wdata` and `rom_addr_hi` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous active-high reset |
| phi2 | input | 1 | Host phase-2 clock level |
| rw | input | 1 | Host read (1) / write (0) |
| io1_n | input | 1 | First I/O page strobe, active low |
| io2_n | input | 1 | Second I/O page strobe, active low |
| roml_n | input | 1 | Host low ROM strobe, active low |
| romh_n | input | 1 | Host high ROM strobe, active low |
| host_addr | input | 16 | Host address bus |
| host_wdata | input | 8 | Host write data |
| page_sel | input | 1 | I/O page choice strap |
| map_swap | input | 1 | Exchanged-half mapping strap |
| rom_en | input | 1 | EPROM enable strap |
| mode128 | input | 1 | EPROM 128-mode strap |
| bank_sel | input | 4 | EPROM bank selector |
| nic_rdata | input | 8 | Controller read data |
| rom_rdata | input | 8 | EPROM read data |
| nic_cs_n | output | 1 | Controller chip select, active low |
| nic_addr | output | 4 | Controller register address |
| isa_ior_n | output | 1 | ISA read strobe, active low |
| isa_iow_n | output | 1 | ISA write strobe, active low |
| nic_wdata | output | 8 | Held write data to controller |
| host_rdata | output | 8 | Read data toward host |
| host_oe | output | 1 | Host data bus drive enable |
| rom_ce_n | output | 1 | EPROM chip enable, active low |
| rom_addr_hi | output | 5 | EPROM address bits 17..13 |
| exrom_n | output | 1 | Cartridge configuration line, active low |
| game_n | output | 1 | Cartridge configuration line, active low |
| host_irq_n | output | 1 | Host interrupt request, never asserted |

## Verification
The hardest case to reach from the ports is a write strobe that spans several clocks while the host changes its data mid-cycle. Catching a latch that follows the bus instead of holding it needs exactly that overlap. The bench holds a write for two clocks, changes `host_wdata` between them, and checks that the output keeps the first value. After a gap, it checks that a fresh write loads the new value. The hidden pair is reached by toggling only `map_swap` at the same offsets, so an address that selects the controller in one layout is shown to be blocked in the other.

// File: rtl/cnic_pkg.sv
package cnic_pkg;

    localparam int NIC_REG_W = 4;
    localparam int WIN_SLOT_W = 4;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_NIC  = 2'd1,
        SRC_ROM  = 2'd2
    } rd_src_e;

    typedef struct packed {
        logic                 cs;
        logic [NIC_REG_W-1:0] reg_a;
        logic                 rd;
        logic                 wr;
    } nic_req_t;

    typedef struct packed {
        logic cs;
        logic a13;
    } rom_req_t;

    // Flip the half-select bit when the exchanged layout is chosen.
    function automatic logic [NIC_REG_W-1:0] map_reg(
        input logic [NIC_REG_W-1:0] off,
        input logic                 swap
    );
        logic [NIC_REG_W-1:0] r;
        r = off;
        r[NIC_REG_W-1] = off[NIC_REG_W-1] ^ swap;
        return r;
    endfunction

    // The lowest byte pair is handed to other cartridge logic when swapped.
    function automatic logic pair_hidden(
        input logic [NIC_REG_W-1:0] off,
        input logic                 swap
    );
        return swap && (off[NIC_REG_W-1:1] == '0);
    endfunction

endpackage

// File: rtl/cnic_io_decode.sv
module cnic_io_decode
    import cnic_pkg::*;
#(
    parameter int BASE_SLOT = 0
) (
    input  logic                 phi2,
    input  logic                 rw,
    input  logic                 io1_n,
    input  logic                 io2_n,
    input  logic                 page_sel,
    input  logic                 map_swap,
    input  logic [7:0]           page_addr,
    output nic_req_t             req
);

    localparam logic [WIN_SLOT_W-1:0] SLOT = WIN_SLOT_W'(BASE_SLOT);

    logic                 page_strobe;
    logic                 slot_hit;
    logic [NIC_REG_W-1:0] off;

    always_comb begin
        page_strobe = page_sel ? ~io2_n : ~io1_n;
        off         = page_addr[NIC_REG_W-1:0];
        slot_hit    = (page_addr[7:NIC_REG_W] == SLOT);
        req.cs      = phi2 && page_strobe && slot_hit && !pair_hidden(off, map_swap);
        req.reg_a   = map_reg(off, map_swap);
        req.rd      = req.cs && rw;
        req.wr      = req.cs && !rw;
    end

endmodule

// File: rtl/cnic_rom_decode.sv
module cnic_rom_decode
    import cnic_pkg::*;
(
    input  logic     phi2,
    input  logic     rw,
    input  logic     rom_en,
    input  logic     mode128,
    input  logic     roml_n,
    input  logic     romh_n,
    input  logic     addr13,
    output rom_req_t req,
    output logic     cfg_exrom_n,
    output logic     cfg_game_n
);

    logic lo_hit;
    logic hi_hit;

    always_comb begin
        lo_hit = !roml_n;
        hi_hit = !romh_n && !mode128;
        req.cs  = rom_en && phi2 && rw && (lo_hit || hi_hit);
        if (mode128) begin
            req.a13 = addr13;
        end else begin
            req.a13 = hi_hit && !lo_hit;
        end
        cfg_exrom_n = !(rom_en && !mode128);
        cfg_game_n  = !(rom_en && !mode128);
    end

endmodule

// File: rtl/cnic_bus_regs.sv
module cnic_bus_regs
    import cnic_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int BANK_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  nic_req_t          nic_d,
    input  rom_req_t          rom_d,
    input  logic              exrom_d,
    input  logic              game_d,
    input  logic [BANK_W-1:0] bank_d,
    input  logic [DATA_W-1:0] wdata_d,
    output nic_req_t          nic_q,
    output rom_req_t          rom_q,
    output logic              exrom_q,
    output logic              game_q,
    output logic [BANK_W-1:0] bank_q,
    output logic [DATA_W-1:0] wdata_q,
    output rd_src_e           src_q
);

    rd_src_e src_d;

    always_comb begin
        if (nic_d.rd) begin
            src_d = SRC_NIC;
        end else if (rom_d.cs) begin
            src_d = SRC_ROM;
        end else begin
            src_d = SRC_NONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            nic_q   <= '0;
            rom_q   <= '0;
            exrom_q <= 1'b1;
            game_q  <= 1'b1;
            bank_q  <= '0;
            src_q   <= SRC_NONE;
        end else begin
            nic_q   <= nic_d;
            rom_q   <= rom_d;
            exrom_q <= exrom_d;
            game_q  <= game_d;
            bank_q  <= bank_d;
            src_q   <= src_d;
        end
    end

    // Write data is captured only when the write strobe opens, then held.
    always_ff @(posedge clk) begin
        if (rst) begin
            wdata_q <= '0;
        end else if (nic_d.wr && !nic_q.wr) begin
            wdata_q <= wdata_d;
        end
    end

endmodule

// File: rtl/cnic_glue.sv
module cnic_glue
    import cnic_pkg::*;
#(
    parameter int BASE_SLOT = 0,
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int BANK_W    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              phi2,
    input  logic              rw,
    input  logic              io1_n,
    input  logic              io2_n,
    input  logic              roml_n,
    input  logic              romh_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              page_sel,
    input  logic              map_swap,
    input  logic              rom_en,
    input  logic              mode128,
    input  logic [BANK_W-1:0] bank_sel,
    input  logic [DATA_W-1:0] nic_rdata,
    input  logic [DATA_W-1:0] rom_rdata,
    output logic              nic_cs_n,
    output logic [3:0]        nic_addr,
    output logic              isa_ior_n,
    output logic              isa_iow_n,
    output logic [DATA_W-1:0] nic_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_oe,
    output logic              rom_ce_n,
    output logic [BANK_W:0]   rom_addr_hi,
    output logic              exrom_n,
    output logic              game_n,
    output logic              host_irq_n
);

    nic_req_t          nic_d, nic_q;
    rom_req_t          rom_d, rom_q;
    logic              exrom_d, game_d;
    logic [BANK_W-1:0] bank_q;
    rd_src_e           src_q;

    cnic_io_decode #(
        .BASE_SLOT (BASE_SLOT)
    ) u_io (
        .phi2      (phi2),
        .rw        (rw),
        .io1_n     (io1_n),
        .io2_n     (io2_n),
        .page_sel  (page_sel),
        .map_swap  (map_swap),
        .page_addr (host_addr[7:0]),
        .req       (nic_d)
    );

    cnic_rom_decode u_rom (
        .phi2        (phi2),
        .rw          (rw),
        .rom_en      (rom_en),
        .mode128     (mode128),
        .roml_n      (roml_n),
        .romh_n      (romh_n),
        .addr13      (host_addr[13]),
        .req         (rom_d),
        .cfg_exrom_n (exrom_d),
        .cfg_game_n  (game_d)
    );

    cnic_bus_regs #(
        .DATA_W (DATA_W),
        .BANK_W (BANK_W)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .nic_d   (nic_d),
        .rom_d   (rom_d),
        .exrom_d (exrom_d),
        .game_d  (game_d),
        .bank_d  (bank_sel),
        .wdata_d (host_wdata),
        .nic_q   (nic_q),
        .rom_q   (rom_q),
        .exrom_q (exrom_n),
        .game_q  (game_n),
        .bank_q  (bank_q),
        .wdata_q (nic_wdata),
        .src_q   (src_q)
    );

    always_comb begin
        nic_cs_n    = !nic_q.cs;
        nic_addr    = nic_q.reg_a;
        isa_ior_n   = !nic_q.rd;
        isa_iow_n   = !nic_q.wr;
        rom_ce_n    = !rom_q.cs;
        rom_addr_hi = {bank_q, rom_q.a13};
        host_irq_n  = 1'b1;
        host_oe     = (src_q != SRC_NONE);
        unique case (src_q)
            SRC_NIC: host_rdata = nic_rdata;
            SRC_ROM: host_rdata = rom_rdata;
            default: host_rdata = '0;
        endcase
    end

endmodule

// File: rtl/cnic_glue_chk.sv
module cnic_glue_chk (
    input logic        clk,
    input logic        rst,
    input logic        map_swap,
    input logic [15:0] host_addr,
    input logic        rom_en,
    input logic        mode128,
    input logic        nic_cs_n,
    input logic        isa_ior_n,
    input logic        isa_iow_n,
    input logic [7:0]  nic_wdata,
    input logic        host_oe,
    input logic        rom_ce_n,
    input logic        exrom_n,
    input logic        game_n,
    input logic        host_irq_n
);

    logic live;
    always_ff @(posedge clk) begin
        if (rst) live <= 1'b0;
        else     live <= 1'b1;
    end

    // R3
    hidden_pair_chk: assert property (@(posedge clk) disable iff (rst || !live)
        ($past(map_swap) && $past(host_addr[3:1]) == 3'b000) |-> nic_cs_n);

    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(!isa_ior_n && !isa_iow_n));

    // R4
    strobe_cs_chk: assert property (@(posedge clk) disable iff (rst)
        (!isa_ior_n || !isa_iow_n) |-> !nic_cs_n);

    // R5
    wdata_hold_chk: assert property (@(posedge clk) disable iff (rst || !live)
        (!isa_iow_n && $past(!isa_iow_n)) |-> $stable(nic_wdata));

    // R6
    oe_source_chk: assert property (@(posedge clk) disable iff (rst)
        host_oe |-> (!isa_ior_n || !rom_ce_n));

    // R7
    irq_idle_chk: assert property (@(posedge clk) disable iff (rst)
        host_irq_n);

    // R8
    rom_off_chk: assert property (@(posedge clk) disable iff (rst || !live)
        !$past(rom_en) |-> (rom_ce_n && exrom_n && game_n));

    // R11
    mode128_cfg_chk: assert property (@(posedge clk) disable iff (rst || !live)
        $past(mode128) |-> (exrom_n && game_n));

endmodule

bind cnic_glue cnic_glue_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .map_swap   (map_swap),
    .host_addr  (host_addr),
    .rom_en     (rom_en),
    .mode128    (mode128),
    .nic_cs_n   (nic_cs_n),
    .isa_ior_n  (isa_ior_n),
    .isa_iow_n  (isa_iow_n),
    .nic_wdata  (nic_wdata),
    .host_oe    (host_oe),
    .rom_ce_n   (rom_ce_n),
    .exrom_n    (exrom_n),
    .game_n     (game_n),
    .host_irq_n (host_irq_n)
);

// File: tb/cnic_glue_tb.sv
module cnic_glue_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        phi2, rw, io1_n, io2_n, roml_n, romh_n;
    logic [15:0] host_addr;
    logic [7:0]  host_wdata;
    logic        page_sel, map_swap, rom_en, mode128;
    logic [3:0]  bank_sel;
    logic [7:0]  nic_rdata, rom_rdata;
    logic        nic_cs_n, isa_ior_n, isa_iow_n, host_oe, rom_ce_n;
    logic        exrom_n, game_n, host_irq_n;
    logic [3:0]  nic_addr;
    logic [7:0]  nic_wdata, host_rdata;
    logic [4:0]  rom_addr_hi;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    cnic_glue u_dut (
        .clk(clk), .rst(rst), .phi2(phi2), .rw(rw), .io1_n(io1_n), .io2_n(io2_n),
        .roml_n(roml_n), .romh_n(romh_n), .host_addr(host_addr),
        .host_wdata(host_wdata), .page_sel(page_sel), .map_swap(map_swap),
        .rom_en(rom_en), .mode128(mode128), .bank_sel(bank_sel),
        .nic_rdata(nic_rdata), .rom_rdata(rom_rdata), .nic_cs_n(nic_cs_n),
        .nic_addr(nic_addr), .isa_ior_n(isa_ior_n), .isa_iow_n(isa_iow_n),
        .nic_wdata(nic_wdata), .host_rdata(host_rdata), .host_oe(host_oe),
        .rom_ce_n(rom_ce_n), .rom_addr_hi(rom_addr_hi), .exrom_n(exrom_n),
        .game_n(game_n), .host_irq_n(host_irq_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_bus();
        phi2 = 1'b0; rw = 1'b1; io1_n = 1'b1; io2_n = 1'b1;
        roml_n = 1'b1; romh_n = 1'b1;
    endtask

    // Apply a bus state at the falling edge, let one rising edge register it.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic io_cycle(input logic rd, input logic page, input logic [15:0] a);
        @(negedge clk);
        idle_bus();
        phi2 = 1'b1; rw = rd; host_addr = a;
        if (page) io2_n = 1'b0; else io1_n = 1'b0;
        step();
    endtask

    task automatic go_idle();
        @(negedge clk);
        idle_bus();
        step();
    endtask

    task automatic t_reset();
        rst = 1'b1;
        idle_bus();
        host_addr = '0; host_wdata = '0; page_sel = 0; map_swap = 0;
        rom_en = 0; mode128 = 0; bank_sel = '0; nic_rdata = 8'h5A; rom_rdata = 8'hC3;
        repeat (3) @(posedge clk);
        #1;
        // R12
        chk("R12 cs", nic_cs_n, 1); chk("R12 ior", isa_ior_n, 1);
        chk("R12 iow", isa_iow_n, 1); chk("R12 oe", host_oe, 0);
        chk("R12 rom", rom_ce_n, 1); chk("R12 exrom", exrom_n, 1);
        chk("R12 addr", nic_addr, 0); chk("R12 wdata", nic_wdata, 0);
        chk("R12 romhi", rom_addr_hi, 0);
        @(negedge clk); rst = 1'b0;
        step();
        chk("R12 after", {nic_cs_n, isa_ior_n, isa_iow_n, host_oe}, 4'b1110);
        // R7
        chk("R7 irq", host_irq_n, 1);
    endtask

    task automatic t_normal_map();
        page_sel = 0; map_swap = 0;
        for (int o = 0; o < 16; o++) begin
            io_cycle(1'b1, 1'b0, 16'hDE00 + 16'(o));
            // R2
            chk("R2 addr", nic_addr, o);
            chk("R1 cs", nic_cs_n, 0);
            // R4
            chk("R4 ior", isa_ior_n, 0);
            chk("R6 data", {host_oe, host_rdata}, {1'b1, 8'h5A});
        end
        go_idle();
        chk("R4 idle", {nic_cs_n, isa_ior_n, isa_iow_n, host_oe}, 4'b1110);
        chk("R6 idle data", host_rdata, 0);
    endtask

    task automatic t_page_select();
        page_sel = 0;
        io_cycle(1'b1, 1'b1, 16'hDF04);
        chk("R1 wrong strobe", nic_cs_n, 1);
        io_cycle(1'b1, 1'b0, 16'hDE14);
        chk("R1 other slot", nic_cs_n, 1);
        page_sel = 1;
        io_cycle(1'b1, 1'b1, 16'hDF06);
        chk("R1 page2 cs", nic_cs_n, 0);
        chk("R1 page2 addr", nic_addr, 6);
        io_cycle(1'b1, 1'b0, 16'hDE06);
        chk("R1 io1 ignored", nic_cs_n, 1);
        @(negedge clk);
        idle_bus(); io2_n = 1'b0; host_addr = 16'hDF06;
        step();
        chk("R1 phi2 low", nic_cs_n, 1);
        page_sel = 0;
        go_idle();
    endtask

    task automatic t_swap_map();
        map_swap = 1;
        io_cycle(1'b1, 1'b0, 16'hDE02);
        // R3
        chk("R3 pp ptr", nic_addr, 4'hA);
        io_cycle(1'b1, 1'b0, 16'hDE08);
        chk("R3 rt data", nic_addr, 4'h0);
        io_cycle(1'b1, 1'b0, 16'hDE0F);
        chk("R3 high", nic_addr, 4'h7);
        io_cycle(1'b1, 1'b0, 16'hDE00);
        chk("R3 hidden cs", nic_cs_n, 1);
        chk("R3 hidden oe", host_oe, 0);
        io_cycle(1'b0, 1'b0, 16'hDE01);
        chk("R3 hidden wr", {nic_cs_n, isa_iow_n}, 2'b11);
        map_swap = 0;
        io_cycle(1'b1, 1'b0, 16'hDE00);
        chk("R3 visible unswapped", nic_cs_n, 0);
        go_idle();
    endtask

    task automatic t_write_hold();
        @(negedge clk); host_wdata = 8'h11;
        io_cycle(1'b0, 1'b0, 16'hDE04);
        chk("R4 iow", isa_iow_n, 0);
        chk("R4 no ior", isa_ior_n, 1);
        chk("R6 no oe on write", host_oe, 0);
        // R5
        chk("R5 capture", nic_wdata, 8'h11);
        @(negedge clk); host_wdata = 8'h22;
        step();
        chk("R5 still low", isa_iow_n, 0);
        chk("R5 held", nic_wdata, 8'h11);
        go_idle();
        chk("R5 released", isa_iow_n, 1);
        @(negedge clk); host_wdata = 8'h33;
        io_cycle(1'b0, 1'b0, 16'hDE05);
        chk("R5 new capture", nic_wdata, 8'h33);
        go_idle();
    endtask

    task automatic rom_cycle(input logic lo, input logic [15:0] a);
        @(negedge clk);
        idle_bus();
        phi2 = 1'b1; rw = 1'b1; host_addr = a;
        if (lo) roml_n = 1'b0; else romh_n = 1'b0;
        step();
    endtask

    task automatic t_rom_disabled();
        rom_en = 0; mode128 = 0;
        rom_cycle(1'b1, 16'h8000);
        // R8
        chk("R8 ce", rom_ce_n, 1);
        chk("R8 cfg", {exrom_n, game_n}, 2'b11);
        chk("R8 oe", host_oe, 0);
        go_idle();
    endtask

    task automatic t_rom64();
        rom_en = 1; mode128 = 0; bank_sel = 4'h9;
        rom_cycle(1'b1, 16'h8123);
        // R10
        chk("R10 lo ce", rom_ce_n, 0);
        chk("R10 cfg", {exrom_n, game_n}, 2'b00);
        // R9
        chk("R9 lo addr", rom_addr_hi, {4'h9, 1'b0});
        chk("R6 rom data", {host_oe, host_rdata}, {1'b1, 8'hC3});
        bank_sel = 4'h6;
        rom_cycle(1'b0, 16'hA000);
        chk("R10 hi ce", rom_ce_n, 0);
        chk("R9 hi addr", rom_addr_hi, {4'h6, 1'b1});
        go_idle();
        chk("R10 idle", {rom_ce_n, host_oe}, 2'b10);
    endtask

    task automatic t_rom128();
        rom_en = 1; mode128 = 1; bank_sel = 4'hF;
        rom_cycle(1'b1, 16'hA000);
        // R11
        chk("R11 ce", rom_ce_n, 0);
        chk("R11 a13", rom_addr_hi, {4'hF, 1'b1});
        chk("R11 cfg", {exrom_n, game_n}, 2'b11);
        rom_cycle(1'b1, 16'h8000);
        chk("R11 a13 low", rom_addr_hi, {4'hF, 1'b0});
        rom_cycle(1'b0, 16'hE000);
        chk("R11 romh ignored", {rom_ce_n, host_oe}, 2'b10);
        rom_en = 0;
        go_idle();
        chk("R7 irq end", host_irq_n, 1);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_normal_map();
                t_page_select();
                t_swap_map();
                t_write_hold();
                t_rom_disabled();
                t_rom64();
                t_rom128();
            end
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        disable fork;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule